// File: doc/BRIEF.md
# Banked Square-Window Pixel Store

This block holds a small greyscale image on chip and returns, for each requested origin coordinate, the full square neighbourhood of pixels below and to the right of that origin. It returns one neighbourhood per clock, whether or not the origin falls on a tile boundary. The image is spread over a grid of banks, one bank for each position inside a square tile. Because of this layout, every window of tile size holds exactly one pixel from each bank. For each window a per-bank address is worked out from the origin, so every bank is read once. A rotating selector then puts the bank outputs back into raster order.

The image is loaded through a simple write port, one pixel per clock. Reads use a valid/ready stream of origins in and a valid/ready stream of windows out. The two read stages stall together when the output is not taken. A window that would run off the right or bottom edge of the image is flagged, and its data is returned as zeros. Typical users are interpolation or convolution datapaths that need a whole neighbourhood for every output sample.

Top module: `pix_window_mem`

## Requirements
- R1: When wr_en_i is high at a clock edge, pixel (wr_x_i, wr_y_i) takes wr_data_i. Every later window that covers that pixel returns the new value, and no other pixel changes.
- R2: In a returned window, the pixel at column offset i and row offset j from the origin (each 0..3) appears on win_data_o bits [8*(4*j+i) +: 8]. Offset (0,0) is therefore in the lowest byte.
- R3: Every in-range origin (both coordinates 0..60), aligned to the 4x4 tile or not, yields its complete 16-pixel window from a single access. Requests can be accepted on every cycle while win_ready_i stays high, and every accepted request produces exactly one window, in request order.
- R4: A request accepted at the clock edge that ends cycle c (req_valid_i and req_ready_o both high) has its window on win_valid_o/win_data_o during cycle c+2, as long as win_ready_i has been high.
- R5: An origin with x > 60 or y > 60 returns win_oor_o = 1 and win_data_o = 0. An origin with both coordinates at most 60 returns win_oor_o = 0.
- R6: When a write and an accepted request fall on the same clock edge, and the write targets a pixel inside the requested window, that window carries the pixel's value from before the write.
- R7: While win_valid_o is high and win_ready_i is low, req_ready_o is low. On the next cycle win_valid_o, win_data_o and win_oor_o keep their values.
- R8: While rst_ni is low, and on the first cycle after it rises, win_valid_o is 0 and req_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Pixel write strobe |
| wr_x_i | input | 6 | Column of pixel to write |
| wr_y_i | input | 6 | Row of pixel to write |
| wr_data_i | input | 8 | Pixel value to write |
| req_valid_i | input | 1 | Window origin valid |
| req_ready_o | output | 1 | Origin accepted when high together with valid |
| req_x_i | input | 6 | Origin column |
| req_y_i | input | 6 | Origin row |
| win_valid_o | output | 1 | Window output valid |
| win_ready_i | input | 1 | Consumer takes window when high together with valid |
| win_data_o | output | 128 | 16 pixels in raster order, byte 4*j+i holds offset (i,j) |
| win_oor_o | output | 1 | Origin would run past the image edge, data forced to zero |

## Verification
The assertions assume that write coordinates and request coordinates are always known values. They also assume that win_ready_i only takes a window when win_valid_o is high. The bench loads every pixel before it issues the first read, so no bank is read before it has been written. Requests, writes and output readiness all change only at the falling edge. Latency is checked only in the phases where win_ready_i is held high. The randomized phase mixes stalls, out-of-range origins and writes that collide with reads, and checks every window that comes out against an image model kept in the bench.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int unsigned DEF_IMG_W = 64;
  localparam int unsigned DEF_IMG_H = 64;
  localparam int unsigned DEF_TILE  = 4;
  localparam int unsigned DEF_PIX_W = 8;
endpackage

// File: rtl/pwm_addr_gen.sv
`timescale 1ns/1ps
// Per-bank local address for a window origin; TILE must be a power of two.
module pwm_addr_gen #(
  parameter int unsigned IMG_W = 64,
  parameter int unsigned IMG_H = 64,
  parameter int unsigned TILE  = 4,
  localparam int unsigned SW    = $clog2(TILE),
  localparam int unsigned XW    = $clog2(IMG_W),
  localparam int unsigned YW    = $clog2(IMG_H),
  localparam int unsigned NB    = TILE * TILE,
  localparam int unsigned TX    = IMG_W / TILE,
  localparam int unsigned DEPTH = TX * (IMG_H / TILE),
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic [XW-1:0]    x_i,
  input  logic [YW-1:0]    y_i,
  output logic [NB*AW-1:0] addr_o,
  output logic             oor_o
);
  logic [SW-1:0]    xm, ym;
  logic [XW-SW-1:0] xt;
  logic [YW-SW-1:0] yt;

  assign xm = x_i[SW-1:0];
  assign ym = y_i[SW-1:0];
  assign xt = x_i[XW-1:SW];
  assign yt = y_i[YW-1:SW];

  for (genvar by = 0; by < TILE; by++) begin : g_row
    for (genvar bx = 0; bx < TILE; bx++) begin : g_col
      logic [XW-SW:0] tcol;
      logic [YW-SW:0] trow;
      // banks left of / above the origin phase come from the next tile
      assign tcol = {1'b0, xt} + (XW-SW+1)'(SW'(bx) < xm);
      assign trow = {1'b0, yt} + (YW-SW+1)'(SW'(by) < ym);
      assign addr_o[(by*TILE+bx)*AW +: AW] = AW'(32'(trow) * TX + 32'(tcol));
    end
  end

  assign oor_o = (x_i > XW'(IMG_W - TILE)) || (y_i > YW'(IMG_H - TILE));

  always_comb begin
    if (!$isunknown({x_i, y_i}) && !oor_o)
      AST_ORIGIN_ADDR: assert (addr_o[(32'(ym)*TILE + 32'(xm))*AW +: AW]
                               == AW'(32'(yt) * TX + 32'(xt))); // R3
  end
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
// One pixel bank: synchronous write, registered read (old data on collision).
module pwm_bank #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned PIX_W = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [PIX_W-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [PIX_W-1:0] rdata_o
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/pwm_switch.sv
`timescale 1ns/1ps
// Rotates bank outputs into raster window order and registers the result.
module pwm_switch #(
  parameter int unsigned TILE  = 4,
  parameter int unsigned PIX_W = 8,
  localparam int unsigned SW   = $clog2(TILE),
  localparam int unsigned NB   = TILE * TILE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                valid_i,
  input  logic                oor_i,
  input  logic [SW-1:0]       xm_i,
  input  logic [SW-1:0]       ym_i,
  input  logic [NB*PIX_W-1:0] bank_i,
  output logic                valid_o,
  output logic                oor_o,
  output logic [NB*PIX_W-1:0] win_o
);
  logic [NB*PIX_W-1:0] lanes;
  logic [PIX_W-1:0]    org_pix;

  for (genvar j = 0; j < TILE; j++) begin : g_wr
    for (genvar i = 0; i < TILE; i++) begin : g_wc
      logic [SW-1:0] sc, sr;
      assign sc = xm_i + SW'(i);
      assign sr = ym_i + SW'(j);
      assign lanes[(j*TILE+i)*PIX_W +: PIX_W] = bank_i[32'({sr, sc})*PIX_W +: PIX_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      oor_o   <= 1'b0;
      win_o   <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      oor_o   <= oor_i;
      win_o   <= oor_i ? '0 : lanes;
    end
  end

  assign org_pix = bank_i[32'({ym_i, xm_i})*PIX_W +: PIX_W];

  AST_LANE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && !oor_i) |=> (win_o[PIX_W-1:0] == $past(org_pix))); // R2
endmodule

// File: rtl/pix_window_mem.sv
`timescale 1ns/1ps
module pix_window_mem #(
  parameter int unsigned IMG_W = pwm_pkg::DEF_IMG_W,
  parameter int unsigned IMG_H = pwm_pkg::DEF_IMG_H,
  parameter int unsigned TILE  = pwm_pkg::DEF_TILE,
  parameter int unsigned PIX_W = pwm_pkg::DEF_PIX_W,
  localparam int unsigned SW    = $clog2(TILE),
  localparam int unsigned XW    = $clog2(IMG_W),
  localparam int unsigned YW    = $clog2(IMG_H),
  localparam int unsigned NB    = TILE * TILE,
  localparam int unsigned BW    = 2 * SW,
  localparam int unsigned TX    = IMG_W / TILE,
  localparam int unsigned DEPTH = TX * (IMG_H / TILE),
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [XW-1:0]       wr_x_i,
  input  logic [YW-1:0]       wr_y_i,
  input  logic [PIX_W-1:0]    wr_data_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [XW-1:0]       req_x_i,
  input  logic [YW-1:0]       req_y_i,
  output logic                win_valid_o,
  input  logic                win_ready_i,
  output logic [NB*PIX_W-1:0] win_data_o,
  output logic                win_oor_o
);
  logic                adv, accept, oor_c;
  logic [NB*AW-1:0]    rd_addr;
  logic [NB*PIX_W-1:0] bank_rd;
  logic [NB-1:0]       bank_we;
  logic [BW-1:0]       wbank;
  logic [AW-1:0]       waddr;
  logic                s1_valid, s1_oor;
  logic [SW-1:0]       s1_xm, s1_ym;

  // single stall for both stages
  assign adv         = !win_valid_o || win_ready_i;
  assign req_ready_o = adv;
  assign accept      = req_valid_i && adv;

  pwm_addr_gen #(.IMG_W(IMG_W), .IMG_H(IMG_H), .TILE(TILE)) u_addr (
    .x_i   (req_x_i),
    .y_i   (req_y_i),
    .addr_o(rd_addr),
    .oor_o (oor_c)
  );

  assign wbank = {wr_y_i[SW-1:0], wr_x_i[SW-1:0]};
  assign waddr = AW'(32'(wr_y_i[YW-1:SW]) * TX + 32'(wr_x_i[XW-1:SW]));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_we[b] = wr_en_i && (wbank == BW'(b));
    pwm_bank #(.DEPTH(DEPTH), .PIX_W(PIX_W)) u_bank (
      .clk_i  (clk_i),
      .we_i   (bank_we[b]),
      .waddr_i(waddr),
      .wdata_i(wr_data_i),
      .re_i   (accept),
      .raddr_i(rd_addr[b*AW +: AW]),
      .rdata_o(bank_rd[b*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_oor   <= 1'b0;
      s1_xm    <= '0;
      s1_ym    <= '0;
    end else if (adv) begin
      s1_valid <= accept;
      s1_oor   <= oor_c;
      s1_xm    <= req_x_i[SW-1:0];
      s1_ym    <= req_y_i[SW-1:0];
    end
  end

  pwm_switch #(.TILE(TILE), .PIX_W(PIX_W)) u_sw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adv),
    .valid_i(s1_valid),
    .oor_i  (s1_oor),
    .xm_i   (s1_xm),
    .ym_i   (s1_ym),
    .bank_i (bank_rd),
    .valid_o(win_valid_o),
    .oor_o  (win_oor_o),
    .win_o  (win_data_o)
  );

  AST_WE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we)); // R1

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && !win_ready_i) |=>
      (win_valid_o && $stable(win_data_o) && $stable(win_oor_o))); // R7
endmodule

// File: tb/sim_pix_window_mem.sv
`timescale 1ns/1ps
module sim_pix_window_mem;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;
  localparam int T = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [5:0]   wr_x_i = '0, wr_y_i = '0;
  logic [7:0]   wr_data_i = '0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [5:0]   req_x_i = '0, req_y_i = '0;
  logic         win_valid_o;
  logic         win_ready_i = 1'b1;
  logic [127:0] win_data_o;
  logic         win_oor_o;

  pix_window_mem u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int img [W][W];
  logic [127:0] q_data [$];
  bit           q_oor  [$];
  int           q_acc  [$];
  string        q_tag  [$];
  int checks = 0, fails = 0, cyc = 0;
  bit lat_chk = 1'b1;
  string cur_tag = "R3";

  task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_win(int x, int y);
    logic [127:0] w = '0;
    if (x > W - T || y > W - T) return '0;
    for (int j = 0; j < T; j++)
      for (int i = 0; i < T; i++)
        w[8*(j*T+i) +: 8] = img[y+j][x+i][7:0];
    return w;
  endfunction

  task automatic check_out();
    if (win_valid_o) begin
      if (q_data.size() == 0) check(1'b0, "R3", "window with no request", 1, 0);
      else begin
        check(win_data_o == q_data[0], q_tag[0], "window data", win_data_o, q_data[0]);
        check(win_oor_o == q_oor[0], "R5", "range flag", win_oor_o, q_oor[0]);
        if (lat_chk) check(cyc - q_acc[0] == 2, "R4", "latency", cyc - q_acc[0], 2);
      end
    end else if (lat_chk && q_data.size() > 0 && cyc - q_acc[0] >= 2)
      check(1'b0, "R4", "window missing", cyc - q_acc[0], 2);
  endtask

  // bookkeeping for the coming edge, then advance to the next falling edge
  task automatic tick();
    #1;
    if (win_valid_o && !win_ready_i)
      check(req_ready_o == 1'b0, "R7", "ready during stall", req_ready_o, 0);
    if (win_valid_o && win_ready_i && q_data.size() > 0) begin
      void'(q_data.pop_front()); void'(q_oor.pop_front());
      void'(q_acc.pop_front());  void'(q_tag.pop_front());
    end
    if (req_valid_i && req_ready_o) begin
      q_data.push_back(exp_win(int'(req_x_i), int'(req_y_i)));
      q_oor.push_back(req_x_i > 6'(W - T) || req_y_i > 6'(W - T));
      q_acc.push_back(cyc);
      q_tag.push_back(cur_tag);
    end
    if (wr_en_i) img[wr_y_i][wr_x_i] = int'(wr_data_i);
    @(negedge clk_i);
    cyc++;
    check_out();
  endtask

  task automatic req(int x, int y, string tag);
    cur_tag = tag;
    req_valid_i = 1'b1;
    req_x_i = 6'(x);
    req_y_i = 6'(y);
    tick();
    req_valid_i = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(win_valid_o == 1'b0 && req_ready_o == 1'b1, "R8", "state in reset",
          {win_valid_o, req_ready_o}, 2'b01);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(win_valid_o == 1'b0 && req_ready_o == 1'b1, "R8", "state after reset",
          {win_valid_o, req_ready_o}, 2'b01);

    // load whole image
    for (int y = 0; y < W; y++)
      for (int x = 0; x < W; x++) begin
        wr_en_i = 1'b1; wr_x_i = 6'(x); wr_y_i = 6'(y);
        wr_data_i = 8'((x * 7 + y * 29 + 3) & 255);
        tick();
      end
    wr_en_i = 1'b0;

    // R2 lane order on aligned origins, R1 loaded contents
    req(0, 0, "R2");
    req(4, 8, "R1");
    req(60, 60, "R5");
    repeat (3) tick();

    // R3 all 16 phases back to back
    for (int ym = 0; ym < T; ym++)
      for (int xm = 0; xm < T; xm++) begin
        cur_tag = "R3"; req_valid_i = 1'b1;
        req_x_i = 6'(21 + xm); req_y_i = 6'(34 + ym);
        tick();
      end
    req_valid_i = 1'b0;
    repeat (3) tick();

    // R5 origins past the edges
    req(61, 0, "R5");
    req(0, 61, "R5");
    req(63, 63, "R5");
    req(60, 62, "R5");
    repeat (3) tick();

    // R6 write colliding with a read of the same window
    wr_en_i = 1'b1; wr_x_i = 6'd18; wr_y_i = 6'd11; wr_data_i = 8'hA5;
    req(17, 9, "R6");
    wr_en_i = 1'b0;
    req(17, 9, "R1");
    req(15, 10, "R1");
    repeat (3) tick();

    // R7 random traffic with backpressure
    lat_chk = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      win_ready_i = ($urandom % 3) != 0;
      req_valid_i = ($urandom % 2) == 1;
      cur_tag = "R7";
      req_x_i = 6'($urandom % 64);
      req_y_i = 6'(($urandom % 8 == 0) ? 61 + ($urandom % 3) : $urandom % 61);
      wr_en_i = ($urandom % 4) == 0;
      wr_x_i = 6'($urandom % 64); wr_y_i = 6'($urandom % 64);
      wr_data_i = 8'($urandom);
      tick();
    end
    req_valid_i = 1'b0; wr_en_i = 1'b0; win_ready_i = 1'b1;
    repeat (4) tick();
    check(q_data.size() == 0, "R3", "windows outstanding", q_data.size(), 0);

    summary();
    $finish;
  end
endmodule